// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a simple word-oriented host port and a single-data-rate synchronous DRAM with four banks, a 16-bit data bus, 13 row address bits and 9 column address bits. It accepts one read or write request at a time and turns it into the command sequence the memory needs. The sequence opens a row, issues a column command with automatic precharge, then moves the data burst. The block also brings the memory up after reset, programs its mode register and inserts periodic refresh.

Commands are carried on the four active-low control lines as {cs_n, ras_n, cas_n, we_n}: 0111 no-op, 0011 open row, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode load. Every pin on the device side comes straight from a register. All delays are module parameters counted in clock cycles. Burst length may be 1, 2, 4 or 8. On a write the host supplies one word with byte enables. That word goes out on the first beat, and the remaining beats of the burst are fully masked. On a read all beats of the burst are returned, one per cycle, with a valid strobe.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is asserted the chip select is high, the clock enable is low, host_ready and host_rvalid are low and the data output enable is low.
- R2: After reset, the first command is issued only after INIT_CYC no-op cycles with the clock enable high. The first commands are then, in order: precharge with A10 high, refresh, refresh, and mode load. The mode load carries the burst length code log2(BURST_LEN) on A[2:0], 0 on A3 (sequential bursts), CAS_LAT on A[6:4] and zeros on A[12:7]. host_ready stays low until the mode load has been issued.
- R3: A host word address splits as row = addr[23:11], bank = addr[10:9], column = addr[8:0]. The open-row command carries that bank on ba and that row on a.
- R4: The column command follows the open-row command by exactly T_RCD cycles. It carries the same bank, the column on A[8:0], A10 high (auto-precharge) and zeros on A9, A11 and A12. It is a write when host_write was 1 and a read otherwise.
- R5: On a write, dq_oe is high for exactly BURST_LEN cycles, starting in the cycle the write command is on the pins. The first beat drives host_wdata with dqm = ~host_be, where bit 0 is the low byte. The later beats drive dqm = 11.
- R6: On a read, host_rvalid is high for BURST_LEN consecutive cycles. It starts CAS_LAT+1 cycles after the read command is on the pins. Beat k returns the word at column {col[8:log2 BL], (col+k) mod BL}, in that order.
- R7: dq_oe is never high in a cycle where host_rvalid is high. dq_oe rises only together with a write command.
- R8: Refresh commands follow one another at intervals within REF_CYC ± (T_RCD+BURST_LEN+CAS_LAT+T_WR+T_RP+2) cycles, with or without traffic. While a refresh is pending, host_ready is low.
- R9: After a read command, no command comes before CAS_LAT+BURST_LEN+T_RP cycles. After a write, none comes before BURST_LEN+T_WR+T_RP cycles. After a refresh the gap is at least T_RFC, after a mode load at least T_MRD, and after a precharge at least T_RP.
- R10: A request is taken in a cycle where host_valid and host_ready are both high, and host_ready is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the memory |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Controller can take a request this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 24 | Word address {row, bank, column} |
| host_wdata | input | 16 | Write word |
| host_be | input | 2 | Byte enables, bit 0 = low byte |
| host_rdata | output | 16 | Read word |
| host_rvalid | output | 1 | host_rdata holds a burst beat |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 13 | Multiplexed row/column address |
| sd_dqm | output | 2 | Byte masks, bit 0 = low byte |
| sd_dq_in | input | 16 | Data from memory |
| sd_dq_out | output | 16 | Data to memory |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |

## Verification
The assertions assume the host holds host_valid and its request fields steady until the request is taken. They also assume the memory returns read data exactly CAS_LAT cycles after it samples a read, which is the behaviour the bench's memory model provides. The bench only changes request fields while host_valid is low or before acceptance, and it drives sd_dq_in only in the read beat windows. The timing parameters are at least 1, and BURST_LEN is one of 1, 2, 4 or 8. The stimulus stays inside that set.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_PREALL,
    ST_INITREF,
    ST_MODE,
    ST_IDLE,
    ST_COL,
    ST_WBEAT,
    ST_WAIT
  } seq_state_e;

  function automatic logic [12:0] mode_word(input int bl, input int cl);
    logic [2:0] code;
    logic [2:0] lat;
    code = (bl == 8) ? 3'd3 : (bl == 4) ? 3'd2 : (bl == 2) ? 3'd1 : 3'd0;
    lat  = 3'(cl);
    return {6'b000000, lat, 1'b0, code};
  endfunction

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] bank,
  output logic [COL_W-1:0]  col
);
  assign col  = addr[COL_W-1:0];
  assign bank = addr[COL_W +: BANK_W];
  assign row  = addr[ADDR_W-1 -: ROW_W];
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int REF_CYC = 1560,
  localparam int CW = $clog2(REF_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic pend
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          tick;

  always_comb begin
    tick   = 1'b0;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (!en) begin
      cnt_d  = CW'(REF_CYC - 1);
      pend_d = 1'b0;
    end else begin
      if (cnt_q == '0) begin
        tick  = 1'b1;
        cnt_d = CW'(REF_CYC - 1);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      pend_d = tick | (pend_q & ~ack);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(REF_CYC - 1);
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R8
  pend_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack && en) |=> pend_q);

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DQ_W      = 16,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  localparam int BW = $clog2(BURST_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_issued,
  input  logic [DQ_W-1:0] dq_in,
  output logic [DQ_W-1:0] rdata,
  output logic            rvalid
);
  logic [CAS_LAT-1:0] sh_q, sh_d;
  logic [BW-1:0]      bcnt_q, bcnt_d;
  logic [DQ_W-1:0]    rdata_q, rdata_d;
  logic               rvalid_q, rvalid_d;
  logic               launch, beat_on;

  assign launch  = sh_q[CAS_LAT-1];
  assign beat_on = launch | (bcnt_q != '0);

  always_comb begin
    sh_d[0] = rd_issued;
    for (int i = 1; i < CAS_LAT; i++) sh_d[i] = sh_q[i-1];
    if (launch)              bcnt_d = BW'(BURST_LEN - 1);
    else if (bcnt_q != '0)   bcnt_d = bcnt_q - 1'b1;
    else                     bcnt_d = bcnt_q;
    rvalid_d = beat_on;
    rdata_d  = beat_on ? dq_in : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      bcnt_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      bcnt_q   <= bcnt_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // R6
  launch_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> rvalid_q);

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int INIT_CYC  = 20000,
  parameter int REF_CYC   = 1560,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 10,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 9,
  parameter int DQ_W      = 16,
  localparam int ADDR_W   = ROW_W + BANK_W + COL_W,
  localparam int BE_W     = DQ_W / 8,
  localparam int RD_HOLD  = CAS_LAT + BURST_LEN + T_RP,
  localparam int WR_HOLD  = BURST_LEN + T_WR + T_RP,
  localparam int CNT_W    = $clog2(INIT_CYC + RD_HOLD + WR_HOLD + T_RFC + T_MRD + T_RCD + 4),
  localparam int BCNT_W   = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DQ_W-1:0]   host_wdata,
  input  logic [BE_W-1:0]   host_be,
  output logic [DQ_W-1:0]   host_rdata,
  output logic              host_rvalid,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [BE_W-1:0]   sd_dqm,
  input  logic [DQ_W-1:0]   sd_dq_in,
  output logic [DQ_W-1:0]   sd_dq_out,
  output logic              sd_dq_oe
);

  localparam logic [ROW_W-1:0] MODE_A = ROW_W'(mode_word(BURST_LEN, CAS_LAT));

  seq_state_e         st_q, st_d, ret_q, ret_d, wait_ret;
  logic [CNT_W-1:0]   cnt_q, cnt_d, wait_len;
  logic [BCNT_W-1:0]  bcnt_q, bcnt_d;
  logic               iref_q, iref_d, init_q, init_d, wait_req;
  logic               req_we_q;
  logic [BANK_W-1:0]  req_ba_q;
  logic [COL_W-1:0]   req_col_q;
  logic [DQ_W-1:0]    req_wd_q;
  logic [BE_W-1:0]    req_be_q;
  logic               take, ref_pend, ref_ack;
  sd_cmd_e            cmd_q, cmd_d;
  logic [BANK_W-1:0]  ba_q, ba_d;
  logic [ROW_W-1:0]   a_q, a_d;
  logic [BE_W-1:0]    dqm_q, dqm_d;
  logic               oe_q, oe_d, cke_q, cke_d;
  logic [DQ_W-1:0]    dout_q, dout_d;
  logic [ROW_W-1:0]   h_row;
  logic [BANK_W-1:0]  h_ba;
  logic [COL_W-1:0]   h_col;

  sdram_addr_split #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_split (
    .addr(host_addr), .row(h_row), .bank(h_ba), .col(h_col)
  );

  sdram_ref_timer #(.REF_CYC(REF_CYC)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(init_q), .ack(ref_ack), .pend(ref_pend)
  );

  sdram_rd_capture #(.DQ_W(DQ_W), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_issued(cmd_q == CMD_RD), .dq_in(sd_dq_in),
    .rdata(host_rdata), .rvalid(host_rvalid)
  );

  assign host_ready = (st_q == ST_IDLE) && !ref_pend;
  assign take       = host_ready && host_valid;

  // next-state and command decision
  always_comb begin
    st_d     = st_q;
    ret_d    = ret_q;
    cnt_d    = cnt_q;
    bcnt_d   = bcnt_q;
    iref_d   = iref_q;
    init_d   = init_q;
    cmd_d    = CMD_NOP;
    ba_d     = ba_q;
    a_d      = a_q;
    dqm_d    = '0;
    oe_d     = 1'b0;
    dout_d   = dout_q;
    cke_d    = cke_q;
    ref_ack  = 1'b0;
    wait_req = 1'b0;
    wait_len = '0;
    wait_ret = ST_IDLE;
    unique case (st_q)
      ST_PWRUP: begin
        cke_d = 1'b1;
        if (cnt_q == '0) st_d = ST_PREALL;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_PREALL: begin
        cmd_d    = CMD_PRE;
        a_d      = '0;
        a_d[10]  = 1'b1;
        iref_d   = 1'b0;
        wait_req = 1'b1;
        wait_len = CNT_W'(T_RP);
        wait_ret = ST_INITREF;
      end
      ST_INITREF: begin
        cmd_d    = CMD_REF;
        iref_d   = 1'b1;
        wait_req = 1'b1;
        wait_len = CNT_W'(T_RFC);
        wait_ret = iref_q ? ST_MODE : ST_INITREF;
      end
      ST_MODE: begin
        cmd_d    = CMD_MRS;
        ba_d     = '0;
        a_d      = MODE_A;
        init_d   = 1'b1;
        wait_req = 1'b1;
        wait_len = CNT_W'(T_MRD);
        wait_ret = ST_IDLE;
      end
      ST_IDLE: begin
        if (ref_pend) begin
          cmd_d    = CMD_REF;
          ref_ack  = 1'b1;
          wait_req = 1'b1;
          wait_len = CNT_W'(T_RFC);
          wait_ret = ST_IDLE;
        end else if (host_valid) begin
          cmd_d    = CMD_ACT;
          ba_d     = h_ba;
          a_d      = h_row;
          wait_req = 1'b1;
          wait_len = CNT_W'(T_RCD);
          wait_ret = ST_COL;
        end
      end
      ST_COL: begin
        cmd_d          = req_we_q ? CMD_WR : CMD_RD;
        ba_d           = req_ba_q;
        a_d            = '0;
        a_d[COL_W-1:0] = req_col_q;
        a_d[10]        = 1'b1;
        if (req_we_q) begin
          oe_d   = 1'b1;
          dout_d = req_wd_q;
          dqm_d  = ~req_be_q;
          if (BURST_LEN > 1) begin
            st_d   = ST_WBEAT;
            bcnt_d = BCNT_W'(BURST_LEN - 2);
          end else begin
            wait_req = 1'b1;
            wait_len = CNT_W'(WR_HOLD);
          end
        end else begin
          wait_req = 1'b1;
          wait_len = CNT_W'(RD_HOLD);
        end
      end
      ST_WBEAT: begin
        oe_d  = 1'b1;
        dqm_d = '1;
        if (bcnt_q == '0) begin
          wait_req = 1'b1;
          wait_len = CNT_W'(1 + T_WR + T_RP);
        end else begin
          bcnt_d = bcnt_q - 1'b1;
        end
      end
      ST_WAIT: begin
        if (cnt_q == '0) st_d = ret_q;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (wait_req) begin
      if (wait_len <= CNT_W'(1)) begin
        st_d = wait_ret;
      end else begin
        st_d  = ST_WAIT;
        cnt_d = wait_len - CNT_W'(2);
        ret_d = wait_ret;
      end
    end
  end

  // state and pin registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PWRUP;
      ret_q  <= ST_IDLE;
      cnt_q  <= CNT_W'(INIT_CYC - 1);
      bcnt_q <= '0;
      iref_q <= 1'b0;
      init_q <= 1'b0;
      cmd_q  <= CMD_DESEL;
      ba_q   <= '0;
      a_q    <= '0;
      dqm_q  <= '0;
      oe_q   <= 1'b0;
      dout_q <= '0;
      cke_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ret_q  <= ret_d;
      cnt_q  <= cnt_d;
      bcnt_q <= bcnt_d;
      iref_q <= iref_d;
      init_q <= init_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      a_q    <= a_d;
      dqm_q  <= dqm_d;
      oe_q   <= oe_d;
      dout_q <= dout_d;
      cke_q  <= cke_d;
    end
  end

  // request capture, clock-enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_we_q  <= 1'b0;
      req_ba_q  <= '0;
      req_col_q <= '0;
      req_wd_q  <= '0;
      req_be_q  <= '0;
    end else if (take) begin
      req_we_q  <= host_write;
      req_ba_q  <= h_ba;
      req_col_q <= h_col;
      req_wd_q  <= host_wdata;
      req_be_q  <= host_be;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_cke    = cke_q;
  assign sd_ba     = ba_q;
  assign sd_a      = a_q;
  assign sd_dqm    = dqm_q;
  assign sd_dq_oe  = oe_q;
  assign sd_dq_out = dout_q;

  // checker: cycles since the last open-row command on the pins
  logic [7:0] since_act_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_act_q <= '0;
    else if (cmd_q == CMD_ACT)   since_act_q <= 8'd1;
    else if (since_act_q != '1)  since_act_q <= since_act_q + 8'd1;
  end

  // R4
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (since_act_q == 8'(T_RCD)));

  // R4
  col_autopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> sd_a[10]);

  // R10
  take_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready) |=> !host_ready);

  // R8
  ref_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !host_ready);

  // R7
  oe_rise_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_dq_oe) |-> (cmd_q == CMD_WR));

  // R7
  no_oe_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> !sd_dq_oe);

  // R2
  ready_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |-> !host_ready);

endmodule

// File: tb/sdram_seq_ctrl_bench.sv
module sdram_seq_ctrl_bench;

  localparam int INIT_CYC = 12;
  localparam int REF_CYC  = 120;
  localparam int T_RCD    = 2;
  localparam int T_RP     = 2;
  localparam int T_RFC    = 6;
  localparam int T_MRD    = 2;
  localparam int T_WR     = 2;
  localparam int CL       = 2;
  localparam int BL       = 4;
  localparam int SLACK    = T_RCD + BL + CL + T_WR + T_RP + 2;

  logic        clk, rst_n;
  logic        host_valid, host_ready, host_write, host_rvalid;
  logic [23:0] host_addr;
  logic [15:0] host_wdata, host_rdata;
  logic [1:0]  host_be;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0]  sd_ba, sd_dqm;
  logic [12:0] sd_a;
  logic [15:0] sd_dq_in, sd_dq_out;

  int checks, failures, cyc;

  sdram_seq_ctrl #(
    .INIT_CYC(INIT_CYC), .REF_CYC(REF_CYC), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .T_WR(T_WR), .CAS_LAT(CL), .BURST_LEN(BL)
  ) u_sdram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_be(host_be), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
    .sd_dq_in(sd_dq_in), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] fval(input int ba, input int row, input int col);
    return 16'(row * 7 + col * 13 + ba * 4099 + 17);
  endfunction

  function automatic int bcol(input int col, input int k);
    return (col & ~(BL - 1)) | ((col + k) & (BL - 1));
  endfunction

  // accepted request, set by the driver
  logic [23:0] acc_addr;
  logic [15:0] acc_wd;
  logic [1:0]  acc_be;
  bit          acc_wr;

  task automatic host_req(input bit wr, input int row, input int ba, input int col,
                          input logic [15:0] wd, input logic [1:0] be);
    @(negedge clk);
    host_valid = 1'b1;
    host_write = wr;
    host_addr  = {13'(row), 2'(ba), 9'(col)};
    host_wdata = wd;
    host_be    = be;
    while (!host_ready) @(negedge clk);
    acc_addr = host_addr;
    acc_wd   = wd;
    acc_be   = be;
    acc_wr   = wr;
    @(negedge clk);
    host_valid = 1'b0;
    // R10: ready drops after acceptance
    chk(!host_ready, "R10", int'(host_ready), 0);
  endtask

  // pin monitor and memory model
  logic [3:0] pcmd;
  int  ncmd, cke_on_cyc, nop_before;
  int  act_cyc, act_row, act_ba;
  int  rd_cyc, wr_cyc, col_cyc, ref_cyc, mrs_cyc, pre_cyc, nref;
  bit  rd_live, wr_live, col_seen, col_wr, ref_seen, mrs_seen, pre_seen, act_seen;
  int  rd_ba_p, rd_row_p, rd_col_p;
  logic [23:0] rd_exp_addr;
  int  k, gap;
  bit  exp_rv, exp_oe;

  always @(negedge clk) begin
    if (rst_n) begin
      pcmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (sd_cke && cke_on_cyc < 0) cke_on_cyc = cyc;
      // memory read data drive
      if (rd_live && cyc >= rd_cyc + CL && cyc < rd_cyc + CL + BL)
        sd_dq_in = fval(rd_ba_p, rd_row_p, bcol(rd_col_p, cyc - rd_cyc - CL));
      else
        sd_dq_in = 16'hDEAD;
      // R2: ready low before mode load issued
      if (ncmd < 4) chk(!host_ready, "R2", int'(host_ready), 0);
      if (!sd_cs_n && pcmd != 4'b0111) begin
        // R9 gaps
        if (col_seen) begin
          gap = cyc - col_cyc;
          chk(gap >= (col_wr ? BL + T_WR + T_RP : CL + BL + T_RP), "R9", gap,
              col_wr ? BL + T_WR + T_RP : CL + BL + T_RP);
          col_seen = 1'b0;
        end
        if (ref_seen) begin
          chk(cyc - ref_cyc >= T_RFC, "R9", cyc - ref_cyc, T_RFC);
          ref_seen = 1'b0;
        end
        if (mrs_seen) begin
          chk(cyc - mrs_cyc >= T_MRD, "R9", cyc - mrs_cyc, T_MRD);
          mrs_seen = 1'b0;
        end
        if (pre_seen) begin
          chk(cyc - pre_cyc >= T_RP, "R9", cyc - pre_cyc, T_RP);
          pre_seen = 1'b0;
        end
        // R2 init order
        if (ncmd == 0) begin
          chk(pcmd == 4'b0010 && sd_a[10], "R2", int'({pcmd, sd_a}), int'({4'b0010, 13'h400}));
          chk(cke_on_cyc >= 0 && cyc - cke_on_cyc >= INIT_CYC, "R2", cyc - cke_on_cyc, INIT_CYC);
        end else if (ncmd == 1 || ncmd == 2) begin
          chk(pcmd == 4'b0001, "R2", int'(pcmd), 1);
        end else if (ncmd == 3) begin
          chk(pcmd == 4'b0000 && sd_a == 13'((CL << 4) | $clog2(BL)), "R2",
              int'({pcmd, sd_a}), int'({4'b0000, 13'((CL << 4) | $clog2(BL))}));
        end
        ncmd++;
        case (pcmd)
          4'b0010: begin pre_seen = 1'b1; pre_cyc = cyc; end
          4'b0000: begin mrs_seen = 1'b1; mrs_cyc = cyc; end
          4'b0001: begin
            // R8: refresh spacing once periodic refreshes are running
            if (nref >= 3)
              chk(cyc - ref_cyc >= REF_CYC - SLACK && cyc - ref_cyc <= REF_CYC + SLACK,
                  "R8", cyc - ref_cyc, REF_CYC);
            nref++;
            ref_seen = 1'b1;
            ref_cyc  = cyc;
          end
          4'b0011: begin
            // R3
            chk(sd_ba == acc_addr[10:9] && sd_a == acc_addr[23:11], "R3",
                int'({sd_ba, sd_a}), int'({acc_addr[10:9], acc_addr[23:11]}));
            act_seen = 1'b1;
            act_cyc = cyc; act_row = int'(sd_a); act_ba = int'(sd_ba);
          end
          4'b0101, 4'b0100: begin
            // R4
            chk(act_seen && cyc - act_cyc == T_RCD, "R4", cyc - act_cyc, T_RCD);
            chk(int'(sd_ba) == act_ba && sd_a[8:0] == acc_addr[8:0] && sd_a[10] &&
                sd_a[12:11] == 2'b00 && !sd_a[9], "R4", int'(sd_a), int'({4'b0010, acc_addr[8:0]}));
            chk(pcmd == (acc_wr ? 4'b0100 : 4'b0101), "R4", int'(pcmd), acc_wr ? 4 : 5);
            act_seen = 1'b0;
            col_seen = 1'b1; col_cyc = cyc; col_wr = (pcmd == 4'b0100);
            if (pcmd == 4'b0100) begin
              wr_live = 1'b1; wr_cyc = cyc;
              // R5 first beat
              chk(sd_dq_out == acc_wd && sd_dqm == ~acc_be, "R5",
                  int'({sd_dqm, sd_dq_out}), int'({~acc_be, acc_wd}));
            end else begin
              rd_live = 1'b1; rd_cyc = cyc;
              rd_ba_p = int'(sd_ba); rd_row_p = act_row; rd_col_p = int'(sd_a[8:0]);
              rd_exp_addr = acc_addr;
            end
          end
          default: ;
        endcase
      end
      // R5 / R7: output enable window and masked later beats
      exp_oe = wr_live && cyc - wr_cyc < BL;
      if (exp_oe || sd_dq_oe) begin
        chk(sd_dq_oe == exp_oe, "R5", int'(sd_dq_oe), int'(exp_oe));
        if (exp_oe && cyc != wr_cyc) chk(sd_dqm == 2'b11, "R5", int'(sd_dqm), 3);
      end
      if (sd_dq_oe && host_rvalid) chk(1'b0, "R7", 1, 0);
      // R6: read return window and order
      k = cyc - rd_cyc - CL - 1;
      exp_rv = rd_live && k >= 0 && k < BL;
      if (exp_rv || host_rvalid) begin
        chk(host_rvalid == exp_rv, "R6", int'(host_rvalid), int'(exp_rv));
        if (exp_rv)
          chk(host_rdata == fval(int'(rd_exp_addr[10:9]), int'(rd_exp_addr[23:11]),
                                 bcol(int'(rd_exp_addr[8:0]), k)),
              "R6", int'(host_rdata),
              int'(fval(int'(rd_exp_addr[10:9]), int'(rd_exp_addr[23:11]),
                        bcol(int'(rd_exp_addr[8:0]), k))));
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; cyc = 0;
    ncmd = 0; nref = 0; cke_on_cyc = -1;
    rd_live = 0; wr_live = 0; col_seen = 0; ref_seen = 0; mrs_seen = 0;
    pre_seen = 0; act_seen = 0; nop_before = 0;
    act_cyc = 0; rd_cyc = 0; wr_cyc = 0; col_cyc = 0; ref_cyc = 0;
    mrs_cyc = 0; pre_cyc = 0;
    host_valid = 0; host_write = 0; host_addr = '0; host_wdata = '0; host_be = '0;
    acc_addr = '0; acc_wd = '0; acc_be = '0; acc_wr = 0;
    sd_dq_in = 16'hDEAD;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sd_cs_n && !sd_cke && !host_ready && !host_rvalid && !sd_dq_oe, "R1",
        int'({sd_cs_n, sd_cke, host_ready, host_rvalid, sd_dq_oe}), 5'b10000);
    rst_n = 1'b1;
    // writes: every bank, every byte-enable pattern, every burst offset
    for (int b = 0; b < 4; b++)
      for (int e = 0; e < 4; e++)
        for (int o = 0; o < 4; o++)
          host_req(1'b1, (b * 977 + e * 31 + o * 5) % 8192, b, ((e * 4 + o) << 4) | o,
                   16'(b * 4096 + e * 256 + o * 16 + 7), 2'(e));
    // reads: every bank and start offset, row and column extremes
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 4; o++)
        host_req(1'b0, (b == 3) ? 8191 : b * 2000 + o, b,
                 (b == 3 && o == 3) ? 511 : (((b * 20 + o) << 2) | o), 16'h0, 2'b00);
    // idle stretch: refresh with no traffic
    repeat (3 * REF_CYC) @(negedge clk);
    // alternating reads and writes
    for (int i = 0; i < 12; i++)
      host_req(i[0], (i * 613) % 8192, i % 4, (i * 37) % 512, 16'(i * 1111), 2'(i % 4));
    repeat (40) @(negedge clk);
    chk(nref >= 6, "R8", nref, 6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule